// File: doc/BRIEF.md
# Configurable Radix-4 Booth Multiplier

This block multiplies two 32-bit operands into a full 64-bit product. A mode input picks whether both operands are read as two's complement or as plain unsigned integers, and the same datapath serves both readings. The multiplier operand is recoded into radix-4 digits drawn from {-2, -1, 0, +1, +2}. Recoding halves the number of partial-product rows. The rows are reduced by a tree of 3:2 carry-save compressors, and one carry-propagate adder forms the result.

Both operands are first extended by sign (signed mode) or by zero (unsigned mode), so one recoding rule covers both modes. A recoded digit of zero means that three-bit window of the multiplier adds nothing. Its row is then forced to all zeros, so that row does not toggle. In signed mode the topmost digit window always holds only sign copies, so that row stays parked. A negative digit inverts its row, and a single correction row holds the +1 for each negative digit at that digit's weight.

Two parameters insert optional register stages. One sits after partial-product selection and one after the compressor tree. A valid flag travels alongside the data, so the latency is fixed at the number of enabled stages. The stage registers load only when a valid operation reaches them.

Top module: `booth_mul`

## Requirements
- R1: With `isSigned` low, `product` equals the unsigned product of `multiplicand` and `multiplier` over the full 2*WIDTH bits.
- R2: With `isSigned` high, `product` equals the two's complement product of the two operands, sign-extended to 2*WIDTH bits.
- R3: Extreme operands give exact results: all-ones times all-ones in unsigned mode, and most-negative times most-negative, most-negative times -1 and most-negative times most-positive in signed mode.
- R4: `outValid` rises exactly LATENCY = PIPE_PP + PIPE_CSA clock cycles after the cycle in which `inValid` was high, one output per accepted operation and in order.
- R5: While `rstN` is low, `outValid` is low from the first clock edge on, and operations in flight are discarded.
- R6: If either operand is zero, the product is zero in both modes.
- R7: In signed mode with both operands nonzero, bit 2*WIDTH-1 of `product` equals the XOR of the two operand sign bits.
- R8: With LATENCY above zero, `product` holds its last value in every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low; clears the valid flags |
| inValid | input | 1 | Operands on this cycle form an operation |
| isSigned | input | 1 | 1: two's complement operands, 0: unsigned operands |
| multiplicand | input | WIDTH | Operand Y, selected into each row as 0, ±Y or ±2Y |
| multiplier | input | WIDTH | Operand X, recoded into radix-4 digits |
| outValid | output | 1 | `product` holds a finished result |
| product | output | 2*WIDTH | Full-width product |

## Verification
The checker assumes that `isSigned` and both operands are stable whenever `inValid` is high, and that they apply only in that one cycle. It also assumes the bench holds `rstN` low from time zero. The stimulus sets operands and mode in the same step as `inValid`, always away from the rising edge, and leaves them unchanged while the pipeline drains. The product check pipes a reference product along with the valid flag. It compares only when `outValid` is high, so the block's values in idle cycles are never taken as results.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Load strobes from the control to the datapath stage registers.
  typedef struct packed {
    logic ppLoad;
    logic csaLoad;
  } stageStrobe_t;

  // Row count left after lvl levels of 3:2 compression.
  function automatic int rowsAfter(input int rows, input int lvl);
    int n;
    n = rows;
    for (int i = 0; i < lvl; i++) n = (n / 3) * 2 + (n % 3);
    return n;
  endfunction

  // Levels of 3:2 compression needed to reach two rows.
  function automatic int csaLevels(input int rows);
    int n;
    int l;
    n = rows;
    l = 0;
    while (n > 2) begin
      n = (n / 3) * 2 + (n % 3);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/booth_row.sv
module booth_row #(
  parameter int WIDTH = 32,
  parameter int SHIFT = 0
) (
  input  logic [2:0]         triple,
  input  logic [WIDTH:0]     yExt,
  output logic [2*WIDTH-1:0] row,
  output logic               negBit
);
  localparam int PW = 2 * WIDTH;
  localparam int MW = WIDTH + 2;

  logic          active;
  logic          single;
  logic [MW-1:0] mag;
  logic [PW-1:0] wide;

  // 000 and 111 recode to digit zero: the row is parked at zero.
  assign active = (triple != 3'b000) && (triple != 3'b111);
  assign single = triple[1] ^ triple[0];
  assign mag    = single ? {yExt[WIDTH], yExt} : {yExt, 1'b0};
  assign negBit = triple[2] & active;
  assign wide   = {{(PW - MW){mag[MW-1]}}, mag} ^ {PW{negBit}};
  assign row    = active ? (wide << SHIFT) : '0;

endmodule

// File: rtl/booth_mul_ctl.sv
module booth_mul_ctl
  import booth_mul_pkg::*;
#(
  parameter bit PIPE_PP  = 1'b1,
  parameter bit PIPE_CSA = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic vldPp;
  logic vldCsa;

  generate
    if (PIPE_PP) begin : g_ppValid
      always_ff @(posedge clk) begin
        if (!rstN) vldPp <= 1'b0;
        else       vldPp <= inValid;
      end
    end else begin : g_ppPass
      assign vldPp = inValid;
    end

    if (PIPE_CSA) begin : g_csaValid
      always_ff @(posedge clk) begin
        if (!rstN) vldCsa <= 1'b0;
        else       vldCsa <= vldPp;
      end
    end else begin : g_csaPass
      assign vldCsa = vldPp;
    end
  endgenerate

  assign strobe.ppLoad  = inValid;
  assign strobe.csaLoad = vldPp;
  assign outValid       = vldCsa;

endmodule

// File: rtl/booth_mul_dp.sv
module booth_mul_dp
  import booth_mul_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter bit PIPE_PP  = 1'b1,
  parameter bit PIPE_CSA = 1'b1
) (
  input  logic               clk,
  input  stageStrobe_t       strobe,
  input  logic               isSigned,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW   = 2 * WIDTH;
  localparam int XB   = ((WIDTH + 2) / 2) * 2;
  localparam int NDIG = XB / 2;
  localparam int NR   = NDIG + 1;
  localparam int NLVL = csaLevels(NR);

  logic [XB:0]     xPad;
  logic [WIDTH:0]  yExt;
  logic [NDIG-1:0] negVec;
  logic [PW-1:0]   rowsD [NR];
  logic [PW-1:0]   rowsS [NR];
  logic [PW-1:0]   lvl   [NLVL+1][NR];
  logic [PW-1:0]   sumD, carryD, sumS, carryS;

  // Sign or zero extension keeps the top digit correct in both modes.
  assign xPad = {{(XB - WIDTH){isSigned & multiplier[WIDTH-1]}}, multiplier, 1'b0};
  assign yExt = {isSigned & multiplicand[WIDTH-1], multiplicand};

  generate
    for (genvar d = 0; d < NDIG; d++) begin : g_digit
      booth_row #(.WIDTH(WIDTH), .SHIFT(2 * d)) u_row (
        .triple(xPad[2*d+2:2*d]),
        .yExt  (yExt),
        .row   (rowsD[d]),
        .negBit(negVec[d])
      );
    end
  endgenerate

  // Correction row: +1 at the weight of every negative digit.
  always_comb begin
    rowsD[NDIG] = '0;
    for (int d = 0; d < NDIG; d++) rowsD[NDIG][2*d] = negVec[d];
  end

  generate
    if (PIPE_PP) begin : g_ppReg
      always_ff @(posedge clk) begin
        if (strobe.ppLoad) rowsS <= rowsD;
      end
    end else begin : g_ppWire
      assign rowsS = rowsD;
    end
  endgenerate

  // Wallace-style tree of 3:2 compressors.
  always_comb begin
    int n;
    logic [PW-1:0] a, b, c;
    for (int l = 0; l <= NLVL; l++)
      for (int k = 0; k < NR; k++) lvl[l][k] = '0;
    for (int k = 0; k < NR; k++) lvl[0][k] = rowsS[k];
    for (int l = 0; l < NLVL; l++) begin
      n = rowsAfter(NR, l);
      for (int g = 0; g < NR / 3; g++) begin
        if (g < n / 3) begin
          a = lvl[l][3*g];
          b = lvl[l][3*g+1];
          c = lvl[l][3*g+2];
          lvl[l+1][2*g]   = a ^ b ^ c;
          lvl[l+1][2*g+1] = ((a & b) | (a & c) | (b & c)) << 1;
        end
      end
      for (int k = 0; k < 2; k++)
        if (k < n % 3) lvl[l+1][2*(n/3)+k] = lvl[l][3*(n/3)+k];
    end
  end

  assign sumD   = lvl[NLVL][0];
  assign carryD = lvl[NLVL][1];

  generate
    if (PIPE_CSA) begin : g_csaReg
      always_ff @(posedge clk) begin
        if (strobe.csaLoad) begin
          sumS   <= sumD;
          carryS <= carryD;
        end
      end
    end else begin : g_csaWire
      assign sumS   = sumD;
      assign carryS = carryD;
    end
  endgenerate

  assign product = sumS + carryS;

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter bit PIPE_PP  = 1'b1,
  parameter bit PIPE_CSA = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               isSigned,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               outValid,
  output logic [2*WIDTH-1:0] product
);
  stageStrobe_t strobe;

  booth_mul_ctl #(.PIPE_PP(PIPE_PP), .PIPE_CSA(PIPE_CSA)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  booth_mul_dp #(.WIDTH(WIDTH), .PIPE_PP(PIPE_PP), .PIPE_CSA(PIPE_CSA)) u_dp (
    .clk         (clk),
    .strobe      (strobe),
    .isSigned    (isSigned),
    .multiplicand(multiplicand),
    .multiplier  (multiplier),
    .product     (product)
  );

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int WIDTH    = 32,
  parameter bit PIPE_PP  = 1'b1,
  parameter bit PIPE_CSA = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               isSigned,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               outValid,
  input logic [2*WIDTH-1:0] product
);
  localparam int PW  = 2 * WIDTH;
  localparam int LAT = int'(PIPE_PP) + int'(PIPE_CSA);

  typedef struct packed {
    logic          vld;
    logic          zero;
    logic          chkSign;
    logic          neg;
    logic [PW-1:0] refP;
  } tapInfo_t;

  tapInfo_t tapNow, tap;
  int       cyc;
  logic     seenOut;

  always_comb begin
    logic signed [PW-1:0] sa, sb;
    sa = isSigned ? PW'($signed(multiplicand)) : PW'(multiplicand);
    sb = isSigned ? PW'($signed(multiplier))   : PW'(multiplier);
    tapNow.vld     = inValid;
    tapNow.zero    = (multiplicand == '0) || (multiplier == '0);
    tapNow.chkSign = isSigned && !tapNow.zero;
    tapNow.neg     = multiplicand[WIDTH-1] ^ multiplier[WIDTH-1];
    tapNow.refP    = PW'(sa * sb);
  end

  generate
    if (LAT == 0) begin : g_tap0
      assign tap = tapNow;
    end else begin : g_tapPipe
      tapInfo_t pipe [LAT];
      always_ff @(posedge clk) begin
        pipe[0] <= tapNow;
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
      end
      assign tap = pipe[LAT-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyc     <= 0;
      seenOut <= 1'b0;
    end else begin
      if (cyc < LAT + 1) cyc <= cyc + 1;
      if (outValid) seenOut <= 1'b1;
    end
  end

  a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= LAT) |-> (outValid == tap.vld));

  // Covers R2 and R3 as well.
  a_r1_product_exact: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (product == tap.refP));

  a_r6_zero_operand: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && tap.zero) |-> (product == '0));

  a_r7_sign_bit: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && tap.chkSign) |-> (product[PW-1] == tap.neg));

  generate
    if (LAT > 0) begin : g_seqChecks
      a_r5_reset_clears: assert property (@(posedge clk)
        !rstN |=> !outValid);
      a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
        (seenOut && !outValid) |-> $stable(product));
    end
  endgenerate

endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH), .PIPE_PP(PIPE_PP), .PIPE_CSA(PIPE_CSA)) u_chk (.*);

// File: tb/test_booth_mul.sv
`timescale 1ns/1ps
module test_booth_mul;
  localparam int BW   = 32;
  localparam int SW   = 6;
  localparam int BLAT = 2;
  localparam int SLAT = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic            bV = 1'b0, bS = 1'b0;
  logic [BW-1:0]   bA = '0, bB = '0;
  logic            bOv;
  logic [2*BW-1:0] bP;
  logic            sV = 1'b0, sS = 1'b0;
  logic [SW-1:0]   sA = '0, sB = '0;
  logic            sOv;
  logic [2*SW-1:0] sP;

  booth_mul #(.WIDTH(BW), .PIPE_PP(1'b1), .PIPE_CSA(1'b1)) i_booth_mul (
    .clk(clk), .rstN(rstN), .inValid(bV), .isSigned(bS),
    .multiplicand(bA), .multiplier(bB), .outValid(bOv), .product(bP));

  booth_mul #(.WIDTH(SW), .PIPE_PP(1'b0), .PIPE_CSA(1'b1)) i_booth_mulSmall (
    .clk(clk), .rstN(rstN), .inValid(sV), .isSigned(sS),
    .multiplicand(sA), .multiplier(sB), .outValid(sOv), .product(sP));

  logic [63:0] bExpQ[$], sExpQ[$];
  string       bTagQ[$], sTagQ[$];
  int          bCycQ[$], sCycQ[$];

  function automatic logic [63:0] refMul(logic [63:0] a, logic [63:0] b, bit sgn, int w);
    logic [63:0] m, p, ma, mb;
    longint sa, sb;
    m  = (w >= 64) ? '1 : ((64'd1 << w) - 1);
    ma = a & m;
    mb = b & m;
    if (sgn) begin
      sa = $signed(ma << (64 - w)) >>> (64 - w);
      sb = $signed(mb << (64 - w)) >>> (64 - w);
    end else begin
      sa = ma;
      sb = mb;
    end
    p = sa * sb;
    return (2 * w >= 64) ? p : (p & ((64'd1 << (2 * w)) - 1));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitors sample at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (bOv) begin
      if (bExpQ.size() == 0) check(1'b0, "R4 unexpected big output", 64'(bP), 64'd0);
      else begin
        logic [63:0] e;
        int c;
        string t;
        e = bExpQ.pop_front(); t = bTagQ.pop_front(); c = bCycQ.pop_front();
        check(bP == e, t, bP, e);
        check(cyc - c == BLAT, "R4 latency big", 64'(cyc - c), 64'(BLAT));
      end
    end
    if (sOv) begin
      if (sExpQ.size() == 0) check(1'b0, "R4 unexpected small output", 64'(sP), 64'd0);
      else begin
        logic [63:0] e;
        int c;
        string t;
        e = sExpQ.pop_front(); t = sTagQ.pop_front(); c = sCycQ.pop_front();
        check(64'(sP) == e, t, 64'(sP), e);
        check(cyc - c == SLAT, "R4 latency small", 64'(cyc - c), 64'(SLAT));
      end
    end
  end

  task automatic driveBig(input logic [BW-1:0] a, input logic [BW-1:0] b, input bit s, input string tag);
    @(negedge clk);
    bA = a; bB = b; bS = s; bV = 1'b1;
    bExpQ.push_back(refMul(64'(a), 64'(b), s, BW));
    bTagQ.push_back(tag);
    bCycQ.push_back(cyc);
  endtask

  task automatic driveSmall(input logic [SW-1:0] a, input logic [SW-1:0] b, input bit s, input string tag);
    @(negedge clk);
    sA = a; sB = b; sS = s; sV = 1'b1;
    sExpQ.push_back(refMul(64'(a), 64'(b), s, SW));
    sTagQ.push_back(tag);
    sCycQ.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bV = 1'b0;
      sV = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(bOv == 1'b0, "R5 reset big", 64'(bOv), 64'd0);
    check(sOv == 1'b0, "R5 reset small", 64'(sOv), 64'd0);
    rstN = 1'b1;

    // Directed vectors on the 32-bit instance.
    driveBig(32'd7, 32'd9, 1'b0, "R1 small unsigned");
    driveBig(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R3 unsigned max");
    driveBig(32'h8000_0000, 32'h8000_0000, 1'b1, "R3 minneg squared");
    driveBig(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R3 minneg times -1");
    driveBig(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R3 minneg times maxpos");
    driveBig(32'h8000_0000, 32'h8000_0000, 1'b0, "R1 unsigned top bits");
    driveBig(32'd0, 32'hDEAD_BEEF, 1'b1, "R6 zero multiplicand");
    driveBig(32'h1234_5678, 32'd0, 1'b0, "R6 zero multiplier");
    driveBig(32'hFFFF_FFFD, 32'd5, 1'b1, "R7 neg times pos");
    driveBig(32'hFFFF_FFFD, 32'hFFFF_FFF9, 1'b1, "R7 neg times neg");
    driveBig(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R1 alternating");
    driveBig(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R2 alternating");
    for (int i = 0; i < 300; i++)
      driveBig($urandom, $urandom, 1'(i & 1), (i & 1) ? "R2 random signed" : "R1 random unsigned");
    idle(1);
    driveBig(32'h0001_0001, 32'hFFFF_0000, 1'b1, "R2 isolated op");
    idle(BLAT + 2);

    // R8: product holds while no operation completes.
    @(negedge clk);
    held = bP;
    idle(4);
    check(bP == held, "R8 hold idle", bP, held);

    // Exhaustive sweep of the 6-bit instance in both modes.
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < (1 << SW); a++)
        for (int b = 0; b < (1 << SW); b++)
          driveSmall(SW'(a), SW'(b), 1'(s), s ? "R2 exhaustive signed" : "R1 exhaustive unsigned");
    idle(SLAT + 2);

    // R5: reset discards operations in flight.
    driveBig(32'd3, 32'd3, 1'b0, "R5 in flight");
    @(negedge clk);
    bV = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    check(bOv == 1'b0, "R5 reset mid-run", 64'(bOv), 64'd0);
    bExpQ.delete(); bTagQ.delete(); bCycQ.delete();
    idle(2);
    check(bOv == 1'b0, "R5 held in reset", 64'(bOv), 64'd0);
    rstN = 1'b1;
    idle(2);
    check(bExpQ.size() == 0 && sExpQ.size() == 0, "R4 queues drained",
          64'(bExpQ.size() + sExpQ.size()), 64'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule